// File: doc/BRIEF.md
# Audio Core Bus Decoder with Configuration Overlay

This block sits between a CPU bus and the register files of a multi-chip audio core. The CPU sees a 64-byte window split into four 16-byte sound-chip banks. A control byte at address 0x0C works as a switch. Writing one magic value there swaps a configuration bank into the second bank's 16 addresses. Writing zero swaps it back out. While the configuration bank is mapped, the second sound bank keeps its contents untouched.

How many physical sound banks exist is fixed at build time by the two low bits of the capability parameter. A quad build has four independent banks. A stereo build folds banks 3 and 4 onto banks 1 and 2. A mono build folds every bank onto bank 1.

The sound chips are modelled as plain 16-byte register files. Byte 0 of each bank is treated as that chip's output level. The levels of the banks on the left side (1 and 3) and on the right side (2 and 4) are summed on two outputs.

Top module: `audio_cfg_decoder`

## Requirements
- R1: After a synchronous reset, the configuration window is unmapped, every bank register and every configuration register is zero, `bus_rdata` is 0x00, and both level sums are zero.
- R2: Reading address 0x0C returns the identifier 0x01. Writing any value to 0x0C other than 0x3F or 0x00 leaves the window state unchanged. Address 0x0C is not a bank register.
- R3: Writing 0x3F to 0x0C maps the configuration bank onto 0x10–0x1F. Writing 0x00 to 0x0C unmaps it. Accesses made while the window is mapped never reach sound bank 2, and its contents return unchanged once the window is unmapped.
- R4: With the window mapped, the configuration offsets behave as follows. Offset 0x10 (mode), 0x15 (secondary-chip mode), 0x16 (alternate-chip mode) and 0x17 (restrict) are 8-bit read/write registers. Offset 0x11 returns the capability parameter and ignores writes. Offsets 0x12, 0x13 and 0x18–0x1F read 0x00.
- R5: Writing a value to offset 0x14 selects a character index from its bits 2:0. A read of 0x14 then returns that character of the 8-character version parameter. Index 0 is the most significant byte of the version parameter.
- R6: In a quad build (capability bits 1:0 = 3), addresses 0x00, 0x10, 0x20 and 0x30 start four independent banks.
- R7: In a stereo build (bits 1:0 = 1 or 2), bank 3 addresses reach bank 1 and bank 4 addresses reach bank 2, so a write to bank 3 overwrites bank 1. In a mono build (bits 1:0 = 0), all four bank ranges reach bank 1.
- R8: `left_sum` is the sum of byte 0 of every distinct physical bank behind banks 1 and 3. `right_sum` is the same sum for banks 2 and 4. In a mono build both sums equal byte 0 of bank 1.
- R9: `chip_split` is 1 exactly when bits 3:2 of the secondary-chip mode register are both 1, which places chip 1 on the left and chip 2 on the right.
- R10: Read data is registered. `bus_rdata` is valid the cycle after a read strobe and holds its value while no read is strobed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Byte address in the 64-byte window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| left_sum | output | 9 | Summed level of left-side banks |
| right_sum | output | 9 | Summed level of right-side banks |
| chip_split | output | 1 | Secondary chips routed one per side |

## Verification
A write takes effect on the clock edge that samples it, and read data appears one edge after its strobe. The bench therefore drives each access on a falling edge and compares `bus_rdata` at the next falling edge, once the sampling rising edge has passed. The level sums pass through one more register than the bank contents, so they are checked only after a full sweep of writes has settled. `chip_split` follows its register directly and is checked one access after the write that sets it. Quad, stereo and mono builds run side by side on the same bus, so every sweep exercises all three folding rules at once.

// File: rtl/audio_dec_pkg.sv
package audio_dec_pkg;

  typedef enum logic [1:0] {
    TGT_BANK = 2'd0,
    TGT_CTRL = 2'd1,
    TGT_CFG  = 2'd2
  } tgt_e;

  localparam logic [5:0] CTRL_ADDR = 6'h0C;
  localparam logic [7:0] MAGIC_ON  = 8'h3F;
  localparam logic [7:0] MAGIC_OFF = 8'h00;
  localparam logic [7:0] ID_VALUE  = 8'h01;

  localparam logic [3:0] CO_MODE  = 4'h0;
  localparam logic [3:0] CO_CAPS  = 4'h1;
  localparam logic [3:0] CO_VER   = 4'h4;
  localparam logic [3:0] CO_SEC   = 4'h5;
  localparam logic [3:0] CO_ALT   = 4'h6;
  localparam logic [3:0] CO_RESTR = 4'h7;

  function automatic int phys_banks(input logic [1:0] code);
    case (code)
      2'd3:    return 4;
      2'd0:    return 1;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/adec_map.sv
module adec_map
  import audio_dec_pkg::*;
#(
  parameter int NPHYS = 4
) (
  input  logic [5:0] addr,
  input  logic       cfg_on,
  output tgt_e       tgt,
  output logic [1:0] pbank,
  output logic [3:0] off
);
  localparam logic [1:0] BMASK = (NPHYS == 4) ? 2'b11 :
                                 (NPHYS == 2) ? 2'b01 : 2'b00;

  always_comb begin
    off   = addr[3:0];
    pbank = addr[5:4] & BMASK;
    if (addr == CTRL_ADDR)
      tgt = TGT_CTRL;
    else if (cfg_on && addr[5:4] == 2'b01)
      tgt = TGT_CFG;
    else
      tgt = TGT_BANK;
  end
endmodule

// File: rtl/adec_banks.sv
module adec_banks #(
  parameter int NPHYS = 4,
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [1:0]                wbank,
  input  logic [$clog2(DEPTH)-1:0]  woff,
  input  logic [DW-1:0]             wdata,
  input  logic [1:0]                rbank,
  input  logic [$clog2(DEPTH)-1:0]  roff,
  output logic [DW-1:0]             rdata,
  output logic [NPHYS-1:0][DW-1:0]  tap0
);
  logic [DW-1:0] bank_rd [NPHYS];

  for (genvar b = 0; b < NPHYS; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
      end else if (we && wbank == 2'(b)) begin
        mem[woff] <= wdata;
      end
    end
    assign bank_rd[b] = mem[roff];
    assign tap0[b]    = mem[0];
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NPHYS; b++)
      if (rbank == 2'(b)) rdata = bank_rd[b];
  end
endmodule

// File: rtl/adec_cfg.sv
module adec_cfg
  import audio_dec_pkg::*;
#(
  parameter logic [7:0]  CAPS    = 8'h1F,
  parameter logic [63:0] VERSION = "CFGW0102"
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [3:0] woff,
  input  logic [7:0] wdata,
  input  logic [3:0] roff,
  output logic [7:0] rdata,
  output logic       chip_split
);
  logic [7:0] mode_q, sec_q, alt_q, restr_q;
  logic [2:0] vidx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      sec_q   <= '0;
      alt_q   <= '0;
      restr_q <= '0;
      vidx_q  <= '0;
    end else if (we) begin
      case (woff)
        CO_MODE:  mode_q  <= wdata;
        CO_VER:   vidx_q  <= wdata[2:0];
        CO_SEC:   sec_q   <= wdata;
        CO_ALT:   alt_q   <= wdata;
        CO_RESTR: restr_q <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (roff)
      CO_MODE:  rdata = mode_q;
      CO_CAPS:  rdata = CAPS;
      CO_VER:   rdata = VERSION[8*(7 - int'(vidx_q)) +: 8];
      CO_SEC:   rdata = sec_q;
      CO_ALT:   rdata = alt_q;
      CO_RESTR: rdata = restr_q;
      default:  rdata = 8'h00;
    endcase
  end

  assign chip_split = (sec_q[3:2] == 2'b11);
endmodule

// File: rtl/audio_cfg_decoder.sv
module audio_cfg_decoder
  import audio_dec_pkg::*;
#(
  parameter logic [7:0]  CAPS    = 8'h1F,
  parameter logic [63:0] VERSION = "CFGW0102",
  parameter int          DW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [5:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [DW:0]   left_sum,
  output logic [DW:0]   right_sum,
  output logic          chip_split
);
  localparam int NPHYS = phys_banks(CAPS[1:0]);

  logic                     cfg_on;
  tgt_e                     tgt;
  logic [1:0]               pbank;
  logic [3:0]               off;
  logic [DW-1:0]            bank_rdata, cfg_rdata;
  logic [NPHYS-1:0][DW-1:0] tap0;

  always_ff @(posedge clk) begin
    if (rst) cfg_on <= 1'b0;
    else if (bus_wr && tgt == TGT_CTRL) begin
      if (bus_wdata == MAGIC_ON)       cfg_on <= 1'b1;
      else if (bus_wdata == MAGIC_OFF) cfg_on <= 1'b0;
    end
  end

  adec_map #(.NPHYS(NPHYS)) u_map (
    .addr(bus_addr), .cfg_on(cfg_on), .tgt(tgt), .pbank(pbank), .off(off)
  );

  adec_banks #(.NPHYS(NPHYS), .DW(DW), .DEPTH(16)) u_banks (
    .clk(clk), .rst(rst),
    .we(bus_wr && tgt == TGT_BANK), .wbank(pbank), .woff(off),
    .wdata(bus_wdata), .rbank(pbank), .roff(off),
    .rdata(bank_rdata), .tap0(tap0)
  );

  adec_cfg #(.CAPS(CAPS), .VERSION(VERSION)) u_cfg (
    .clk(clk), .rst(rst),
    .we(bus_wr && tgt == TGT_CFG), .woff(off), .wdata(bus_wdata[7:0]),
    .roff(off), .rdata(cfg_rdata), .chip_split(chip_split)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (tgt)
        TGT_CTRL: bus_rdata <= DW'(ID_VALUE);
        TGT_CFG:  bus_rdata <= cfg_rdata;
        default:  bus_rdata <= bank_rdata;
      endcase
    end
  end

  logic [DW:0] left_d, right_d;
  if (NPHYS == 4) begin : g_quad
    assign left_d  = {1'b0, tap0[0]} + {1'b0, tap0[2]};
    assign right_d = {1'b0, tap0[1]} + {1'b0, tap0[3]};
  end else if (NPHYS == 2) begin : g_stereo
    assign left_d  = {1'b0, tap0[0]};
    assign right_d = {1'b0, tap0[1]};
  end else begin : g_mono
    assign left_d  = {1'b0, tap0[0]};
    assign right_d = {1'b0, tap0[0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_sum  <= '0;
      right_sum <= '0;
    end else begin
      left_sum  <= left_d;
      right_sum <= right_d;
    end
  end
endmodule

// File: rtl/adec_chk.sv
module adec_chk #(
  parameter logic [7:0] CAPS = 8'h1F
) (
  input logic       clk,
  input logic       rst,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [5:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       cfg_on
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!cfg_on && bus_rdata == 8'h00));

  p_id_value_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 6'h0C) |=> bus_rdata == 8'h01);

  p_ctrl_other_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 6'h0C && bus_wdata != 8'h3F && bus_wdata != 8'h00)
      |=> $stable(cfg_on));

  p_map_on_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 6'h0C && bus_wdata == 8'h3F) |=> cfg_on);

  p_map_off_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 6'h0C && bus_wdata == 8'h00) |=> !cfg_on);

  p_caps_ro_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && cfg_on && bus_addr == 6'h11) |=> bus_rdata == CAPS);

  p_hole_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && cfg_on && (bus_addr == 6'h12 || bus_addr == 6'h1F))
      |=> bus_rdata == 8'h00);

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind audio_cfg_decoder adec_chk #(.CAPS(CAPS)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata[7:0]),
  .bus_rdata(bus_rdata[7:0]), .cfg_on(cfg_on)
);

// File: tb/audio_cfg_decoder_tb.sv
module audio_cfg_decoder_tb;
  localparam logic [63:0] VER = "CFGW0102";
  localparam logic [7:0] CAP_Q = 8'h1F, CAP_S = 8'h3D, CAP_M = 8'h60;

  logic clk = 1'b0, rst = 1'b1;
  logic wr = 1'b0, rd = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rq, rs, rm;
  logic [8:0] lq, rqs, ls, rss, lm, rms;
  logic sq, ss, sm;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  audio_cfg_decoder #(.CAPS(CAP_Q), .VERSION(VER)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rq), .left_sum(lq), .right_sum(rqs),
    .chip_split(sq));
  audio_cfg_decoder #(.CAPS(CAP_S), .VERSION(VER)) u_st (
    .clk(clk), .rst(rst), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rs), .left_sum(ls), .right_sum(rss),
    .chip_split(ss));
  audio_cfg_decoder #(.CAPS(CAP_M), .VERSION(VER)) u_mo (
    .clk(clk), .rst(rst), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rm), .left_sum(lm), .right_sum(rms),
    .chip_split(sm));

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 8'hFF);
  endfunction

  function automatic logic [7:0] vchar(input int i);
    return 8'(VER >> (8 * (7 - i)));
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [8:0] act, input logic [8:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "rdata q", {1'b0, rq}, 9'h0);
    chk("R1", "left q", lq, 9'h0);
    chk("R1", "right s", rss, 9'h0);
    chk("R1", "split m", {8'h0, sm}, 9'h0);
    bus_read(6'h25);
    chk("R1", "bank zero", {1'b0, rq}, 9'h0);

    // R6 R7: write sweep with window unmapped (ascending addresses)
    for (int a = 0; a < 64; a++)
      if (a != 12) bus_write(6'(a), pat(a));
    for (int a = 0; a < 64; a++) begin
      bus_read(6'(a));
      if (a == 12) begin
        chk("R2", "id q", {1'b0, rq}, 9'h01);
        chk("R2", "id s", {1'b0, rs}, 9'h01);
        chk("R2", "id m", {1'b0, rm}, 9'h01);
      end else begin
        chk("R6", "quad bank", {1'b0, rq}, {1'b0, pat(a)});
        chk("R7", "stereo fold", {1'b0, rs}, {1'b0, pat(a | 32)});
        chk("R7", "mono fold", {1'b0, rm}, {1'b0, pat((a & 15) | 48)});
      end
    end

    // R10: rdata holds with no read strobe
    repeat (3) @(negedge clk);
    chk("R10", "hold", {1'b0, rq}, {1'b0, pat(63)});

    // R8 level sums
    chk("R8", "quad left", lq, 9'(pat(0)) + 9'(pat(32)));
    chk("R8", "quad right", rqs, 9'(pat(16)) + 9'(pat(48)));
    chk("R8", "stereo left", ls, 9'(pat(32)));
    chk("R8", "stereo right", rss, 9'(pat(48)));
    chk("R8", "mono left", lm, 9'(pat(48)));
    chk("R8", "mono right", rms, 9'(pat(48)));

    // R2: other values to 0x0C keep window unmapped
    bus_write(6'h0C, 8'h55);
    bus_read(6'h11);
    chk("R2", "still unmapped", {1'b0, rq}, {1'b0, pat(17)});

    // R3 map window
    bus_write(6'h0C, 8'h3F);
    bus_read(6'h11);
    chk("R4", "caps q", {1'b0, rq}, {1'b0, CAP_Q});
    chk("R4", "caps s", {1'b0, rs}, {1'b0, CAP_S});
    chk("R4", "caps m", {1'b0, rm}, {1'b0, CAP_M});
    bus_write(6'h0C, 8'h12);
    bus_read(6'h11);
    chk("R2", "still mapped", {1'b0, rq}, {1'b0, CAP_Q});

    // R4 sweep of configuration offsets
    for (int o = 0; o < 16; o++) bus_write(6'(16 + o), 8'(8'hA0 + o * 3));
    for (int o = 0; o < 16; o++) begin
      logic [7:0] e;
      bus_read(6'(16 + o));
      case (o)
        0, 5, 6, 7: e = 8'(8'hA0 + o * 3);
        1:          e = CAP_Q;
        4:          e = vchar((8'hA0 + 12) & 7);
        default:    e = 8'h00;
      endcase
      chk("R4", "cfg offset", {1'b0, rq}, {1'b0, e});
    end

    // R9 split: offset 0x15 held 0xAF (bits 3:2 = 11)
    chk("R9", "split on", {8'h0, sq}, 9'h1);
    bus_write(6'h15, 8'h08);
    @(negedge clk);
    chk("R9", "split off", {8'h0, sq}, 9'h0);
    bus_write(6'h15, 8'h0C);
    @(negedge clk);
    chk("R9", "split on again", {8'h0, ss}, 9'h1);

    // R5 version window sweep
    for (int i = 0; i < 8; i++) begin
      bus_write(6'h14, 8'(8'hF8 | i));
      bus_read(6'h14);
      chk("R5", "version char", {1'b0, rq}, {1'b0, vchar(i)});
    end

    // R3 unmap: bank 2 contents survive, sums unchanged
    bus_write(6'h0C, 8'h00);
    for (int o = 0; o < 16; o++) begin
      bus_read(6'(16 + o));
      chk("R3", "bank2 kept q", {1'b0, rq}, {1'b0, pat(16 + o)});
      chk("R3", "bank2 kept s", {1'b0, rs}, {1'b0, pat(48 + o)});
    end
    chk("R3", "sum kept", rqs, 9'(pat(16)) + 9'(pat(48)));

    // R7 stereo overwrite through bank 3
    bus_write(6'h20, 8'h77);
    bus_read(6'h00);
    chk("R7", "stereo overwrite", {1'b0, rs}, 9'h077);
    chk("R6", "quad independent", {1'b0, rq}, {1'b0, pat(0)});
    @(negedge clk);
    chk("R8", "quad left new", lq, 9'(pat(0)) + 9'h077);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule